// File: doc/BRIEF.md
# External interrupt sense and flag unit

This block turns eight asynchronous interrupt request pins into eight latched request flags. Software gives each pin a two-bit detection mode: low level, falling edge, rising edge or either edge. When the selected condition is seen on a pin, that line's flag is set. The flag drives a per-line request output, and the OR of all flags drives a single combined request.

Software reaches the block through a small register bus. It has an address, read and write strobes, write data and registered read data. Two registers hold the detection modes, four lines per register. A third register shows the flags. A flag is cleared in one of two ways. Software can write 0 to it, but only after a status read has returned that flag as 1. The CPU can also acknowledge the line when it enters interrupt handling. For a level-mode line, the acknowledge clears the flag only when the pin has returned high. Priority, vectoring and masking belong to the interrupt controller that consumes the request outputs.

Top module: `ext_irq_unit`

## Requirements
- R1: After synchronous reset, all flags, all request outputs, all mode fields and the read data are 0.
- R2: Address 0 holds the modes of lines 0 to 3 and address 1 holds those of lines 4 to 7. Line n uses bits 2*(n mod 4)+1 : 2*(n mod 4) of its register. Written values read back unchanged, with read data valid one cycle after the read strobe. Address 3 reads 0 and ignores writes.
- R3: Mode 00 (low level) sets the flag while the synchronized pin is low. The flag stays set after the pin returns high until it is cleared.
- R4: Mode 01 sets the flag on a falling edge, 10 on a rising edge and 11 on either edge. A pin change driven before rising clock edge k shows on the flag after edge k+2, and not after edge k+1.
- R5: Address 2 is the status register, with bit n being line n's flag. Writing 1 to a flag bit has no effect.
- R6: Writing 0 to a flag bit at address 2 clears it only if the most recent status read returned that bit as 1. The next status write consumes that permission, whether or not it clears the flag.
- R7: In mode 00, an acknowledge on line n clears the flag only while the synchronized pin is high.
- R8: In modes 01, 10 and 11, an acknowledge on line n clears the flag unconditionally.
- R9: A detection event in the same cycle as a write clear or an acknowledge leaves the flag set.
- R10: Request output bit n equals flag n, and the combined request equals the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous interrupt request pins |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ack_i | input | 8 | Per-line interrupt acknowledge |
| req_o | output | 8 | Per-line request, equal to the flags |
| req_any_o | output | 1 | OR of all flags |

## Verification
A detection event can land in the same cycle as a clear, whether the clear comes from an armed status write or from an acknowledge. Directed cases create this overlap on purpose. In one, an acknowledge is placed on the cycle in which the bench knows a fresh both-edges event is active. In another, a low-level pin is held low while the line is acknowledged and then cleared by an armed write. The flag must survive in both cases. Random pin toggles, acknowledges and status accesses produce many more overlaps. Each one is judged against a cycle-accurate reference model in the bench, in which a set always wins over a clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  // Detection condition for one line given its mode and two successive
  // synchronized samples.
  function automatic logic sense_hit(input logic [1:0] mode,
                                     input logic cur,
                                     input logic prev);
    logic hit;
    case (sense_e'(mode))
      SENSE_LOW:  hit = ~cur;
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      default:    hit = prev ^ cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] sync_o,
  output logic [NUM_LINES-1:0] prev_o
);

  logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;

  // Reset to 1 so that an idle-high pin shows no edge after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        stage_q[s] <= '1;
      end
      prev_q <= '1;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign sync_o = stage_q[SYNC_STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic [2*NUM_LINES-1:0] sense_i,
  input  logic [NUM_LINES-1:0]   sync_i,
  input  logic [NUM_LINES-1:0]   prev_i,
  output logic [NUM_LINES-1:0]   evt_o
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign evt_o[i] = sense_hit(sense_i[2*i +: 2], sync_i[i], prev_i[i]);
  end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_LINES-1:0]   evt_i,
  input  logic [NUM_LINES-1:0]   ack_i,
  input  logic [NUM_LINES-1:0]   pin_sync_i,
  input  logic [2*NUM_LINES-1:0] sense_i,
  input  logic                   st_rd_i,
  input  logic                   st_wr_i,
  input  logic [NUM_LINES-1:0]   st_wdata_i,
  output logic [NUM_LINES-1:0]   flag_o,
  output logic                   any_o
);

  logic [NUM_LINES-1:0] flag_q;
  logic [NUM_LINES-1:0] arm_q;
  logic [NUM_LINES-1:0] ack_clr;
  logic [NUM_LINES-1:0] wr_clr;
  logic [NUM_LINES-1:0] flag_d;
  logic                 any_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ack
    // Level mode keeps the flag while the pin is still asserted.
    assign ack_clr[i] = ack_i[i] &
                        ((sense_i[2*i +: 2] != SENSE_LOW) | pin_sync_i[i]);
  end

  assign wr_clr = {NUM_LINES{st_wr_i}} & arm_q & ~st_wdata_i;
  assign flag_d = evt_i | (flag_q & ~(wr_clr | ack_clr));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      any_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      any_q  <= |flag_d;
    end
  end

  // Permission to clear is taken on a status read and spent on the next write.
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= '0;
    end else if (st_rd_i) begin
      arm_q <= flag_q;
    end else if (st_wr_i) begin
      arm_q <= '0;
    end
  end

  assign flag_o = flag_q;
  assign any_o  = any_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NUM_LINES      = 8,
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 2,
  parameter int NUM_SENSE_REGS = 2,
  parameter int STATUS_ADDR    = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic [NUM_LINES-1:0]   flag_i,
  output logic [2*NUM_LINES-1:0] sense_o,
  output logic                   st_rd_o,
  output logic                   st_wr_o,
  output logic [DATA_W-1:0]      rdata_o
);

  localparam int FIELDS_PER_REG = DATA_W / 2;

  logic [DATA_W-1:0] sense_q [NUM_SENSE_REGS];
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              hit_status;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_SENSE_REGS; r++) begin
        sense_q[r] <= '0;
      end
    end else if (bus_wr) begin
      for (int r = 0; r < NUM_SENSE_REGS; r++) begin
        if (bus_addr == ADDR_W'(r)) begin
          sense_q[r] <= bus_wdata;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_field
    assign sense_o[2*i +: 2] =
      sense_q[i / FIELDS_PER_REG][2*(i % FIELDS_PER_REG) +: 2];
  end

  assign hit_status = (bus_addr == ADDR_W'(STATUS_ADDR));
  assign st_rd_o    = bus_rd & hit_status;
  assign st_wr_o    = bus_wr & hit_status;

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_SENSE_REGS; r++) begin
      if (bus_addr == ADDR_W'(r)) begin
        rd_mux = sense_q[r];
      end
    end
    if (hit_status) begin
      rd_mux = DATA_W'(flag_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int NUM_LINES   = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] req_o,
  output logic                 req_any_o
);

  localparam int FIELDS_PER_REG = DATA_W / 2;
  localparam int NUM_SENSE_REGS = (NUM_LINES + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int STATUS_ADDR    = NUM_SENSE_REGS;

  logic [2*NUM_LINES-1:0] sense_q;
  logic [NUM_LINES-1:0]   pin_sync;
  logic [NUM_LINES-1:0]   pin_prev;
  logic [NUM_LINES-1:0]   evt;
  logic [NUM_LINES-1:0]   flag_q;
  logic                   st_rd;
  logic                   st_wr;

  irq_sync #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) sync_i (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .sync_o(pin_sync),
    .prev_o(pin_prev)
  );

  irq_detect #(
    .NUM_LINES(NUM_LINES)
  ) detect_i (
    .sense_i(sense_q),
    .sync_i (pin_sync),
    .prev_i (pin_prev),
    .evt_o  (evt)
  );

  irq_regs #(
    .NUM_LINES     (NUM_LINES),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .NUM_SENSE_REGS(NUM_SENSE_REGS),
    .STATUS_ADDR   (STATUS_ADDR)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .flag_i   (flag_q),
    .sense_o  (sense_q),
    .st_rd_o  (st_rd),
    .st_wr_o  (st_wr),
    .rdata_o  (bus_rdata)
  );

  irq_flag_bank #(
    .NUM_LINES(NUM_LINES)
  ) flags_i (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt),
    .ack_i     (ack_i),
    .pin_sync_i(pin_sync),
    .sense_i   (sense_q),
    .st_rd_i   (st_rd),
    .st_wr_i   (st_wr),
    .st_wdata_i(bus_wdata[NUM_LINES-1:0]),
    .flag_o    (flag_q),
    .any_o     (req_any_o)
  );

  assign req_o = flag_q;

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int NUM_LINES   = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_LINES-1:0]   pin_sync,
  input logic [NUM_LINES-1:0]   evt,
  input logic [2*NUM_LINES-1:0] sense_q,
  input logic [NUM_LINES-1:0]   ack_i,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic [NUM_LINES-1:0]   req_o,
  input logic                   req_any_o
);

  logic was_rst = 1'b0;

  always_ff @(posedge clk) was_rst <= rst;

  always_ff @(posedge clk) begin
    if (was_rst && !rst) begin
      AST_RESET_IDLE: assert (req_o == '0 && !req_any_o); // R1
    end
  end

  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (rst)
    req_any_o == (|req_o)); // R10

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> req_o[i]); // R9

    AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ack_i[i] && sense_q[2*i +: 2] != 2'b00 && !evt[i]) |=> !req_o[i]); // R8

    AST_LEVEL_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (ack_i[i] && sense_q[2*i +: 2] == 2'b00 && !pin_sync[i] && req_o[i])
      |=> req_o[i]); // R7

    AST_ONE_NO_SET: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(STATUS_ADDR) && bus_wdata[i] &&
       !req_o[i] && !evt[i]) |=> !req_o[i]); // R5
  end

endmodule

bind ext_irq_unit ext_irq_chk #(
  .NUM_LINES  (NUM_LINES),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .STATUS_ADDR(STATUS_ADDR)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .pin_sync (pin_sync),
  .evt      (evt),
  .sense_q  (sense_q),
  .ack_i    (ack_i),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .req_o    (req_o),
  .req_any_o(req_any_o)
);

// File: tb/ext_irq_unit_tb_top.sv
module ext_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin = 8'hFF;
  logic [1:0] addr = 2'd0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ack = 8'h00;
  logic [7:0] rdata;
  logic [7:0] req;
  logic       req_any;

  int n_checks = 0;
  int n_err    = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  bit cmp_en   = 1'b0;

  always #10 clk = ~clk;

  ext_irq_unit dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .bus_addr(addr), .bus_rd(rd),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .ack_i(ack),
    .req_o(req), .req_any_o(req_any)
  );

  // Reference model built from the requirements.
  logic [7:0] m_s0, m_s1, m_prev, m_flag, m_arm;
  logic       m_any;
  logic [1:0] m_sense [8];

  function automatic logic f_event(input logic [1:0] mode, input logic cur, input logic prv);
    case (mode)
      2'b00:   return !cur;
      2'b01:   return prv && !cur;
      2'b10:   return !prv && cur;
      default: return prv != cur;
    endcase
  endfunction

  function automatic logic [7:0] f_pack(input int r);
    logic [7:0] v;
    for (int j = 0; j < 4; j++) v[2*j +: 2] = m_sense[4*r + j];
    return v;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nf;
    logic clr;
    if (rst) begin
      m_s0 <= 8'hFF; m_s1 <= 8'hFF; m_prev <= 8'hFF;
      m_flag <= 8'h00; m_arm <= 8'h00; m_any <= 1'b0;
      for (int i = 0; i < 8; i++) m_sense[i] <= 2'b00;
    end else begin
      m_s0 <= pin; m_s1 <= m_s0; m_prev <= m_s1;
      for (int i = 0; i < 8; i++) begin
        clr = (wr && addr == 2'd2 && m_arm[i] && !wdata[i]) ||
              (ack[i] && (m_sense[i] != 2'b00 || m_s1[i]));
        nf[i] = f_event(m_sense[i], m_s1[i], m_prev[i]) || (m_flag[i] && !clr);
      end
      m_flag <= nf;
      m_any  <= |nf;
      if (rd && addr == 2'd2) m_arm <= m_flag;
      else if (wr && addr == 2'd2) m_arm <= 8'h00;
      if (wr && addr < 2'd2)
        for (int j = 0; j < 4; j++) m_sense[4*addr + j] <= wdata[2*j +: 2];
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R4 R10 flags vs model", req, m_flag);
      check("R10 combined request", {7'd0, req_any}, {7'd0, m_any});
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
    wr = 1'b0;
  endtask

  task automatic bus_read(input string tag, input logic [1:0] a);
    logic [7:0] exp;
    addr = a; rd = 1'b1;
    exp = (a == 2'd2) ? m_flag : (a < 2'd2) ? f_pack(int'(a)) : 8'h00;
    cyc();
    rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_err++;
      $display("FAIL watchdog R1..: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    cyc(3);
    rst = 1'b0;
    cyc();
    cmp_en = 1'b1;
    // R1 reset state
    check("R1 req after reset", req, 8'h00);
    check("R1 any after reset", {7'd0, req_any}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);
    bus_read("R1 mode reg0 reset", 2'd0);
    bus_read("R1 mode reg1 reset", 2'd1);
    bus_read("R1 status reset", 2'd2);
    // R2 mode registers: line0 low, 1 fall, 2 rise, 3 both; 4 fall, 5 rise, 6 both, 7 low
    bus_write(2'd0, 8'hE4);
    bus_write(2'd1, 8'h39);
    bus_read("R2 mode reg0 readback", 2'd0);
    check("R2 mode reg0 value", rdata, 8'hE4);
    bus_read("R2 mode reg1 readback", 2'd1);
    check("R2 mode reg1 value", rdata, 8'h39);
    bus_write(2'd3, 8'hFF);
    bus_read("R2 unused address", 2'd3);
    check("R2 unused reads zero", rdata, 8'h00);
    bus_read("R2 reg0 untouched", 2'd0);
    check("R2 reg0 still", rdata, 8'hE4);
    // R4 falling edge latency on line1
    pin[1] = 1'b0;
    cyc(2);
    check("R4 not yet after two edges", req, 8'h00);
    cyc();
    check("R4 falling edge sets line1", req, 8'h02);
    check("R10 any set", {7'd0, req_any}, 8'h01);
    // R4 rising-only line ignores fall, fires on rise
    pin[2] = 1'b0;
    cyc(3);
    check("R4 rise mode ignores fall", req, 8'h02);
    pin[2] = 1'b1;
    cyc(3);
    check("R4 rise mode fires", req, 8'h06);
    ack = 8'h04; cyc(); ack = 8'h00;
    check("R8 ack clears edge line2", req, 8'h02);
    // R5 writing ones
    bus_write(2'd2, 8'hFF);
    check("R5 write one no effect", req, 8'h02);
    // R6 unarmed clear
    bus_write(2'd2, 8'h00);
    check("R6 unarmed write keeps flag", req, 8'h02);
    bus_read("R5 status bit position", 2'd2);
    check("R5 status value", rdata, 8'h02);
    bus_write(2'd2, 8'h00);
    check("R6 armed write clears", req, 8'h00);
    check("R10 any clear", {7'd0, req_any}, 8'h00);
    // R6 arming consumed by intervening write
    pin[1] = 1'b1; cyc(3);
    pin[1] = 1'b0; cyc(3);
    check("R4 second fall", req, 8'h02);
    bus_read("R6 read arms", 2'd2);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd2, 8'h00);
    check("R6 arming consumed", req, 8'h02);
    ack = 8'h02; cyc(); ack = 8'h00;
    check("R8 ack clears edge line1", req, 8'h00);
    // R3 / R7 level mode on line0
    pin[0] = 1'b0; cyc(3);
    check("R3 low level sets", req, 8'h01);
    ack = 8'h01; cyc(); ack = 8'h00;
    check("R7 ack with pin low keeps", req, 8'h01);
    bus_read("R9 arm level line", 2'd2);
    bus_write(2'd2, 8'h00);
    check("R9 set beats write clear", req, 8'h01);
    pin[0] = 1'b1; cyc(3);
    check("R3 flag sticky after release", req, 8'h01);
    ack = 8'h01; cyc(); ack = 8'h00;
    check("R7 ack with pin high clears", req, 8'h00);
    // R9 both-edge event coincides with acknowledge on line3
    pin[3] = 1'b0; cyc(3);
    check("R4 both mode fall", req, 8'h08);
    pin[3] = 1'b1; cyc(2);
    ack = 8'h08; cyc(); ack = 8'h00;
    check("R9 set beats ack", req, 8'h08);
    ack = 8'h08; cyc(); ack = 8'h00;
    check("R8 ack clears both-mode", req, 8'h00);
    // Random phase against the model
    for (int k = 0; k < 4000; k++) begin
      int op;
      logic [7:0] t1, t2;
      t1 = 8'($urandom); t2 = 8'($urandom);
      pin = pin ^ (t1 & t2);
      t1 = 8'($urandom);
      ack = ($urandom % 6 == 0) ? (t1 & 8'($urandom)) : 8'h00;
      op = int'($urandom % 16);
      if (op == 0) bus_read("R5 R6 random status read", 2'd2);
      else if (op == 1) bus_write(2'd2, 8'($urandom));
      else if (op == 2) bus_write(2'($urandom % 2), 8'($urandom));
      else if (op == 3) bus_read("R2 random mode read", 2'($urandom % 2));
      else cyc();
    end
    ack = 8'h00;
    cyc(2);
    finish_run();
  end

endmodule